// File: doc/BRIEF.md
# Cache Occupancy Usage Monitor

This block keeps one usage counter per monitoring-counter ID (MCID) and lets software drive them through a small memory-mapped window. Software writes a command word into the control register to attach a counter to an event, or to copy a counter into a read-only snapshot register. Every command finishes in the cycle it is written. The control register then holds the written fields and a result code.

A second input port reports occupancy changes from the cache. Each change is a block allocated or freed, tagged with an MCID and an access type. Each active counter whose ID and access-type filter match counts the change. A counter that was just configured reports its value as not yet valid until it sees its first change. Which lines belong to which MCID is decided outside this block.

Top module: `occ_mon_ctrl`

## Requirements
- R1: Reads return data one cycle after `bus_rd`. Offset 8 returns the control register, offset 16 returns the counter snapshot register, and any other offset returns 0.
- R2: A write to offset 8 loads the command fields: opcode in bits 4:0, access type in 7:5, MCID in 19:8, event in 27:20 and filter-enable in bit 28. The result code goes to bits 38:32. The register reads back every written field exactly, with bits 31:29 and 63:40 at 0.
- R3: After reset both registers read 0 and every counter is inactive. The busy flag in bit 39 always reads 0, because every command completes in one cycle.
- R4: An MCID at or above `NUM_MCID` gives result 3 whatever the opcode is, and changes no counter or snapshot.
- R5: Opcode 1 configures an event and opcode 2 reads a counter. Any other opcode with a valid MCID gives result 2.
- R6: Configuring event 0 deactivates the counter and gives result 1. Configuring an event other than 0 or 1 gives result 4.
- R7: Configuring event 1 (occupancy) with the filter-enable bit set and an access type outside `SUP_AT` gives result 5 and changes nothing. By default only types 0 (data) and 1 (code) are supported. With filter-enable clear, the access type is not checked, and the counter then matches every access type.
- R8: A successful occupancy configuration gives result 1 and sets the counter to exactly bit 63 (not-yet-valid) with a count of 0.
- R9: A read command with a valid MCID gives result 1 and copies that counter's 64-bit value into the snapshot register.
- R10: Writes to the snapshot register offset, or to any offset other than 8, change neither register.
- R11: An occupancy change hits an active counter when its MCID equals the counter's ID and its access type passes the counter's filter. A hit clears bit 63 and adds 1 for an allocation or subtracts 1 for a free.
- R12: A free that hits a counter holding 0 leaves the count at 0 but still clears bit 63.
- R13: A change aimed at an inactive counter, at a filtered-out access type, or at an MCID out of range alters no counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, registered, valid one cycle after bus_rd |
| occ_valid | input | 1 | An occupancy change is presented |
| occ_alloc | input | 1 | 1 for a block allocated, 0 for a block freed |
| occ_mcid | input | 12 | MCID that owns the changed block |
| occ_at | input | 3 | Access type of the change |

## Verification
The bench builds the block with `NUM_MCID` at 16 and leaves `SUP_AT` at its default. With 16 counters, random commands often carry MCIDs of 16 to 19, so the range check is hit often. The few live counters also receive enough allocations and frees that counts rise, fall back to zero and saturate there. Random access types 0 to 3 reach both the supported and the unsupported side of the filter check.

// File: rtl/occ_mon_pkg.sv
package occ_mon_pkg;
  localparam int MCID_W = 12;
  localparam int CTL_OFF = 8;
  localparam int SNAP_OFF = 16;

  localparam logic [4:0] OP_CFG = 5'd1;
  localparam logic [4:0] OP_READ = 5'd2;
  localparam logic [7:0] EV_NONE = 8'd0;
  localparam logic [7:0] EV_OCC = 8'd1;

  typedef enum logic [6:0] {
    RES_IDLE = 7'd0,
    RES_OK = 7'd1,
    RES_BAD_OP = 7'd2,
    RES_BAD_ID = 7'd3,
    RES_BAD_EV = 7'd4,
    RES_BAD_AT = 7'd5
  } result_e;

  function automatic logic [63:0] pack_ctl(input logic [4:0] op, input logic [2:0] at,
                                           input logic [MCID_W-1:0] id, input logic [7:0] ev,
                                           input logic flt, input logic [6:0] res);
    logic [63:0] v;
    v = '0;
    v[4:0] = op;
    v[7:5] = at;
    v[19:8] = id;
    v[27:20] = ev;
    v[28] = flt;
    v[38:32] = res;
    return v;
  endfunction
endpackage

// File: rtl/occ_mon_decode.sv
module occ_mon_decode
  import occ_mon_pkg::*;
#(
  parameter int NUM_MCID = 256,
  parameter logic [7:0] SUP_AT = 8'h03
) (
  input  logic [4:0]        op,
  input  logic [2:0]        at,
  input  logic [MCID_W-1:0] id,
  input  logic [7:0]        ev,
  input  logic              flt,
  output result_e           res,
  output logic              cfg_fire,
  output logic              cfg_on,
  output logic              rd_fire
);
  logic in_range;
  assign in_range = (32'(id) < NUM_MCID);

  always_comb begin
    res = RES_BAD_OP;
    cfg_fire = 1'b0;
    cfg_on = 1'b0;
    rd_fire = 1'b0;
    if (!in_range) begin
      res = RES_BAD_ID;
    end else if (op == OP_CFG) begin
      if (ev == EV_NONE) begin
        res = RES_OK;
        cfg_fire = 1'b1;
      end else if (ev == EV_OCC) begin
        if (flt && !SUP_AT[at]) begin
          res = RES_BAD_AT;
        end else begin
          res = RES_OK;
          cfg_fire = 1'b1;
          cfg_on = 1'b1;
        end
      end else begin
        res = RES_BAD_EV;
      end
    end else if (op == OP_READ) begin
      res = RES_OK;
      rd_fire = 1'b1;
    end
  end
endmodule

// File: rtl/occ_mon_entry.sv
module occ_mon_entry (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_hit,
  input  logic        cfg_on,
  input  logic        cfg_flt,
  input  logic [2:0]  cfg_at,
  input  logic        upd_hit,
  input  logic        upd_alloc,
  input  logic [2:0]  upd_at,
  output logic [63:0] value
);
  logic        act_q;
  logic        flt_q;
  logic [2:0]  at_q;
  logic        inv_q;
  logic [62:0] cnt_q;
  logic        match;

  assign match = act_q && upd_hit && (!flt_q || (at_q == upd_at));
  assign value = {inv_q, cnt_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      flt_q <= 1'b0;
      at_q <= '0;
      inv_q <= 1'b0;
      cnt_q <= '0;
    end else if (cfg_hit) begin
      act_q <= cfg_on;
      if (cfg_on) begin
        flt_q <= cfg_flt;
        at_q <= cfg_at;
        inv_q <= 1'b1;
        cnt_q <= '0;
      end
    end else if (match) begin
      inv_q <= 1'b0;
      if (upd_alloc) cnt_q <= cnt_q + 63'd1;
      else if (cnt_q != '0) cnt_q <= cnt_q - 63'd1;
    end
  end
endmodule

// File: rtl/occ_mon_ctrl.sv
module occ_mon_ctrl
  import occ_mon_pkg::*;
#(
  parameter int NUM_MCID = 256,
  parameter int ADDR_W = 12,
  parameter logic [7:0] SUP_AT = 8'h03
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [63:0]       bus_wdata,
  output logic [63:0]       bus_rdata,
  input  logic              occ_valid,
  input  logic              occ_alloc,
  input  logic [11:0]       occ_mcid,
  input  logic [2:0]        occ_at
);
  localparam int IDX_W = (NUM_MCID > 1) ? $clog2(NUM_MCID) : 1;

  logic [63:0] ctl_q;
  logic [63:0] ctrval_q;
  logic [63:0] entry_val [NUM_MCID];

  logic              wr_ctl;
  logic [4:0]        w_op;
  logic [2:0]        w_at;
  logic [MCID_W-1:0] w_id;
  logic [7:0]        w_ev;
  logic              w_flt;
  result_e           d_res;
  logic              d_cfg, d_on, d_rd;
  logic              unused_wdata;

  assign w_op = bus_wdata[4:0];
  assign w_at = bus_wdata[7:5];
  assign w_id = bus_wdata[19:8];
  assign w_ev = bus_wdata[27:20];
  assign w_flt = bus_wdata[28];
  assign unused_wdata = ^bus_wdata[63:29];
  assign wr_ctl = bus_wr && (32'(bus_addr) == CTL_OFF) && !ctl_q[39];

  occ_mon_decode #(.NUM_MCID(NUM_MCID), .SUP_AT(SUP_AT)) u_dec (
    .op(w_op), .at(w_at), .id(w_id), .ev(w_ev), .flt(w_flt),
    .res(d_res), .cfg_fire(d_cfg), .cfg_on(d_on), .rd_fire(d_rd)
  );

  for (genvar i = 0; i < NUM_MCID; i++) begin : g_ctr
    occ_mon_entry u_ent (
      .clk(clk), .rst(rst),
      .cfg_hit(wr_ctl && d_cfg && (w_id == MCID_W'(i))),
      .cfg_on(d_on), .cfg_flt(w_flt), .cfg_at(w_at),
      .upd_hit(occ_valid && (occ_mcid == MCID_W'(i))),
      .upd_alloc(occ_alloc), .upd_at(occ_at),
      .value(entry_val[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      ctrval_q <= '0;
    end else if (wr_ctl) begin
      ctl_q <= pack_ctl(w_op, w_at, w_id, w_ev, w_flt, d_res);
      if (d_rd) ctrval_q <= entry_val[w_id[IDX_W-1:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (32'(bus_addr) == CTL_OFF) bus_rdata <= ctl_q;
      else if (32'(bus_addr) == SNAP_OFF) bus_rdata <= ctrval_q;
      else bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/occ_mon_chk.sv
module occ_mon_chk
  import occ_mon_pkg::*;
#(
  parameter int NUM_MCID = 256,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [63:0]       bus_wdata,
  input logic [63:0]       bus_rdata,
  input logic [63:0]       ctl_q,
  input logic [63:0]       ctrval_q
);
  logic ctl_wr;
  assign ctl_wr = bus_wr && (32'(bus_addr) == CTL_OFF);

  // R3
  busy_low_chk: assert property (@(posedge clk) disable iff (rst) !ctl_q[39]);

  // R2
  echo_fields_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> (ctl_q[28:0] == $past(bus_wdata[28:0])));

  // R4
  bad_id_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && (32'(bus_wdata[19:8]) >= NUM_MCID)) |=>
      (ctl_q[38:32] == 7'd3) && $stable(ctrval_q));

  // R10
  ctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl_wr |=> $stable(ctl_q) && $stable(ctrval_q));

  // R1
  snap_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (32'(bus_addr) == SNAP_OFF)) |=> (bus_rdata == $past(ctrval_q)));
endmodule

bind occ_mon_ctrl occ_mon_chk #(.NUM_MCID(NUM_MCID), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctl_q(ctl_q), .ctrval_q(ctrval_q)
);

// File: tb/test_occ_mon_ctrl.sv
`timescale 1ns/1ps
module test_occ_mon_ctrl;
  localparam int NM = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic        occ_valid = 1'b0, occ_alloc = 1'b0;
  logic [11:0] occ_mcid = '0;
  logic [2:0]  occ_at = '0;

  int checks = 0, fails = 0;
  bit done = 0;

  logic        m_act [NM];
  logic        m_flt [NM];
  logic [2:0]  m_at  [NM];
  logic        m_inv [NM];
  logic [62:0] m_cnt [NM];
  logic [63:0] m_snap;
  logic [63:0] m_ctl;

  always #2.5 clk = ~clk;

  occ_mon_ctrl #(.NUM_MCID(NM), .ADDR_W(12)) i_occ_mon_ctrl (.*);

  function automatic logic [6:0] exp_res(input logic [4:0] op, input logic [2:0] at,
                                         input logic [11:0] id, input logic [7:0] ev,
                                         input logic flt);
    if (id >= NM) return 7'd3;
    if (op == 5'd1) begin
      if (ev == 8'd0) return 7'd1;
      if (ev != 8'd1) return 7'd4;
      if (flt && at > 3'd1) return 7'd5;
      return 7'd1;
    end
    if (op == 5'd2) return 7'd1;
    return 7'd2;
  endfunction

  function automatic logic [63:0] ctl_word(input logic [4:0] op, input logic [2:0] at,
                                           input logic [11:0] id, input logic [7:0] ev,
                                           input logic flt, input logic [6:0] r);
    logic [63:0] v = '0;
    v[4:0] = op; v[7:5] = at; v[19:8] = id; v[27:20] = ev; v[28] = flt; v[38:32] = r;
    return v;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input int addr, input logic [63:0] exp, input string req);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 12'(addr);
    @(negedge clk);
    bus_rd = 1'b0;
    check(req, bus_rdata, exp);
  endtask

  task automatic ctl_op(input logic [4:0] op, input logic [2:0] at, input logic [11:0] id,
                        input logic [7:0] ev, input logic flt, input string req);
    logic [6:0] r;
    r = exp_res(op, at, id, ev, flt);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 12'd8;
    bus_wdata = ctl_word(op, at, id, ev, flt, 7'd0) | 64'hFFFF_FF00_E000_0000;
    @(negedge clk);
    bus_wr = 1'b0;
    if (r == 7'd1 && op == 5'd1) begin
      m_act[id[3:0]] = (ev == 8'd1);
      if (ev == 8'd1) begin
        m_flt[id[3:0]] = flt; m_at[id[3:0]] = at;
        m_inv[id[3:0]] = 1'b1; m_cnt[id[3:0]] = '0;
      end
    end
    if (r == 7'd1 && op == 5'd2) m_snap = {m_inv[id[3:0]], m_cnt[id[3:0]]};
    m_ctl = ctl_word(op, at, id, ev, flt, r);
    rd_chk(8, m_ctl, req);
    if (op == 5'd2) rd_chk(16, m_snap, req);
  endtask

  task automatic occ(input logic alloc, input logic [11:0] id, input logic [2:0] at);
    @(negedge clk);
    occ_valid = 1'b1; occ_alloc = alloc; occ_mcid = id; occ_at = at;
    if (id < NM && m_act[id[3:0]] && (!m_flt[id[3:0]] || m_at[id[3:0]] == at)) begin
      m_inv[id[3:0]] = 1'b0;
      if (alloc) m_cnt[id[3:0]] = m_cnt[id[3:0]] + 63'd1;
      else if (m_cnt[id[3:0]] != '0) m_cnt[id[3:0]] = m_cnt[id[3:0]] - 63'd1;
    end
    @(negedge clk);
    occ_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int seed;
    seed = 32'h5EED_1234;
    void'($urandom(seed));
    for (int i = 0; i < NM; i++) begin
      m_act[i] = 0; m_flt[i] = 0; m_at[i] = 0; m_inv[i] = 0; m_cnt[i] = 0;
    end
    m_snap = '0; m_ctl = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R3 reset state, R1 unmapped offset
    rd_chk(8, 64'd0, "R3");
    rd_chk(16, 64'd0, "R3");
    rd_chk(24, 64'd0, "R1");

    // R4 bad MCID with any opcode
    ctl_op(5'd7, 3'd2, 12'd16, 8'd9, 1'b1, "R4");
    ctl_op(5'd2, 3'd0, 12'hFFF, 8'd0, 1'b0, "R4");
    // R5 unknown opcode
    ctl_op(5'd3, 3'd0, 12'd2, 8'd1, 1'b0, "R5");
    // R6 bad event, R7 unsupported type with and without filter
    ctl_op(5'd1, 3'd0, 12'd2, 8'd2, 1'b0, "R6");
    ctl_op(5'd1, 3'd5, 12'd2, 8'd1, 1'b1, "R7");
    ctl_op(5'd2, 3'd0, 12'd2, 8'd0, 1'b0, "R7");
    ctl_op(5'd1, 3'd5, 12'd3, 8'd1, 1'b0, "R7");
    // R8 fresh counter reads with only bit 63 set
    ctl_op(5'd2, 3'd0, 12'd3, 8'd0, 1'b0, "R8");
    check("R8", m_snap, 64'h8000_0000_0000_0000);
    // R12 free at zero saturates and clears invalid
    occ(1'b0, 12'd3, 3'd6);
    ctl_op(5'd2, 3'd0, 12'd3, 8'd0, 1'b0, "R12");
    check("R12", m_snap, 64'd0);
    // R11 allocations counted
    occ(1'b1, 12'd3, 3'd1); occ(1'b1, 12'd3, 3'd4);
    ctl_op(5'd2, 3'd0, 12'd3, 8'd0, 1'b0, "R11");
    check("R11", m_snap, 64'd2);
    // R13 filtered counter ignores other access type
    ctl_op(5'd1, 3'd1, 12'd4, 8'd1, 1'b1, "R13");
    occ(1'b1, 12'd4, 3'd0);
    ctl_op(5'd2, 3'd0, 12'd4, 8'd0, 1'b0, "R13");
    check("R13", m_snap, 64'h8000_0000_0000_0000);
    // R6 deactivation stops counting
    ctl_op(5'd1, 3'd0, 12'd3, 8'd0, 1'b0, "R6");
    occ(1'b1, 12'd3, 3'd0);
    ctl_op(5'd2, 3'd0, 12'd3, 8'd0, 1'b0, "R6");
    check("R6", m_snap, 64'd2);
    // R10 writes to snapshot and other offsets ignored
    @(negedge clk); bus_wr = 1'b1; bus_addr = 12'd16; bus_wdata = '1;
    @(negedge clk); bus_addr = 12'd0;
    @(negedge clk); bus_wr = 1'b0;
    rd_chk(16, m_snap, "R10");
    rd_chk(8, m_ctl, "R10");

    // R9 random commands and updates
    for (int it = 0; it < 400; it++) begin
      int nu;
      logic [4:0] op;
      nu = int'($urandom_range(0, 4));
      for (int k = 0; k < nu; k++)
        occ(1'($urandom), 12'($urandom_range(0, 19)), 3'($urandom_range(0, 3)));
      case ($urandom_range(0, 5))
        0, 1: op = 5'd1;
        2, 3: op = 5'd2;
        4: op = 5'd0;
        default: op = 5'd5;
      endcase
      ctl_op(op, 3'($urandom_range(0, 3)), 12'($urandom_range(0, 19)),
             ($urandom_range(0, 3) == 3) ? 8'd3 : 8'($urandom_range(0, 1)),
             1'($urandom), "R9");
    end
    finish_run();
  end
endmodule